// File: doc/BRIEF.md
# Dual-Level Password Access Gate

This block decides whether a protected memory command may go ahead. It stores two 64-bit passwords. One is a read-level password and the other is a full-access password. It also stores one arm byte that switches password checking on or off. Software loads these registers through a byte-write port. There is no read path, so the stored passwords can never be observed.

The bus master sends a candidate password one bit at a time. The candidate is framed by a start strobe and an end strobe. The end strobe also carries the command kind: protected read or protected copy. One cycle after the end strobe, the block raises either a grant pulse or a deny pulse.

Checking is armed only when the arm byte holds exactly 8'hAA. While it is disarmed, any candidate of exactly 64 bits is granted. A protected read passes if the candidate matches either stored password. A protected copy passes only if it matches the full-access password.

Top module: `pwd_access_gate`

## Requirements
- R1: After reset no grant or deny pulse is present, both passwords are zero, and the arm byte is 8'h00, so checking starts disarmed.
- R2: While the arm byte is not 8'hAA, every candidate of exactly 64 bits is granted, for both read and copy.
- R3: While armed, a read (cmd_copy_i = 0 at the end strobe) is granted when the candidate equals the read-level password or the full-access password. Any other candidate is denied.
- R4: While armed, a copy (cmd_copy_i = 1 at the end strobe) is granted only when the candidate equals the full-access password. A candidate equal to only the read-level password is denied.
- R5: A candidate with fewer or more than 64 bits is denied, whether checking is armed or not.
- R6: Candidate bit k is the k-th bit accepted after the start strobe, counting from bit 0.
- R7: Byte-write address a in 0..7 loads read-level password bits [8a+7:8a]. Address 8+a loads the same bits of the full-access password. Address 16 loads the arm byte. Writes to addresses 17..31 change nothing.
- R8: For each end strobe that closes an open candidate, exactly one of grant_o or deny_o is high, for one cycle only, in the cycle after the strobe.
- R9: An end strobe with no open candidate produces no pulse. Bits presented while no candidate is open are ignored. A start strobe takes priority over a bit or an end strobe in the same cycle.
- R10: Only the exact value 8'hAA arms checking. A near value such as 8'hAB leaves the block disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Byte-write strobe |
| cfg_addr_i | input | 5 | Byte-write address |
| cfg_wdata_i | input | 8 | Byte-write data |
| cand_start_i | input | 1 | Opens a new candidate and clears the collected bits |
| cand_vld_i | input | 1 | A candidate bit is present |
| cand_bit_i | input | 1 | Candidate bit value |
| cand_end_i | input | 1 | Closes the candidate and requests a decision |
| cmd_copy_i | input | 1 | Command kind at the end strobe: 0 read, 1 copy |
| grant_o | output | 1 | One-cycle grant pulse |
| deny_o | output | 1 | One-cycle deny pulse |

## Verification
The assertions check the following on every cycle:
- Grant and deny are never high together.
- A pulse appears only right after an end strobe.
- An end strobe with no open candidate stays silent.
- A length other than 64 always ends in deny.
- A 64-bit candidate is always granted while the arm byte is not 8'hAA.

Only the bench scenarios can show the rest:
- Which stored password a candidate matched, and how read and copy differ in that choice.
- Bit order on the serial input.
- The byte-address layout of the stored words, and that writes to unused addresses have no effect.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  localparam int unsigned PW_BYTES_DEF = 8;
  localparam logic [7:0]  ARM_CODE     = 8'hAA;
  localparam logic [7:0]  ARM_RST      = 8'h00;
  typedef enum logic {CMD_READ = 1'b0, CMD_COPY = 1'b1} cmd_e;
endpackage

// File: rtl/pwg_cfg_regs.sv
module pwg_cfg_regs #(
  parameter int unsigned PW_BYTES = 8,
  localparam int unsigned PW_W    = PW_BYTES * 8,
  localparam int unsigned ADDR_W  = $clog2(2 * PW_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [PW_W-1:0]   rd_pw_o,
  output logic [PW_W-1:0]   full_pw_o,
  output logic [7:0]        arm_o
);
  localparam logic [ADDR_W-1:0] ARM_ADDR = ADDR_W'(2 * PW_BYTES);

  for (genvar b = 0; b < PW_BYTES; b++) begin : g_byte
    localparam logic [ADDR_W-1:0] RD_ADDR   = ADDR_W'(b);
    localparam logic [ADDR_W-1:0] FULL_ADDR = ADDR_W'(PW_BYTES + b);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_pw_o[8*b +: 8]   <= '0;
        full_pw_o[8*b +: 8] <= '0;
      end else if (we_i) begin
        if (addr_i == RD_ADDR)   rd_pw_o[8*b +: 8]   <= wdata_i;
        if (addr_i == FULL_ADDR) full_pw_o[8*b +: 8] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          arm_o <= pwg_pkg::ARM_RST;
    else if (we_i && addr_i == ARM_ADDR)  arm_o <= wdata_i;
  end
endmodule

// File: rtl/pwg_rx.sv
module pwg_rx #(
  parameter int unsigned PW_W   = 64,
  localparam int unsigned CNT_W = $clog2(PW_W + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             vld_i,
  input  logic             bit_i,
  input  logic             end_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [PW_W-1:0]  cand_o
);
  // counter saturates one past full length: enough to flag "too long"
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(PW_W + 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_o    <= '0;
      cand_o   <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      cnt_o    <= '0;
      cand_o   <= '0;
    end else if (active_o && end_i) begin
      active_o <= 1'b0;
    end else if (active_o && vld_i) begin
      cand_o <= {bit_i, cand_o[PW_W-1:1]};   // first bit lands in LSB after PW_W shifts
      if (cnt_o != CNT_SAT) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/pwg_decide.sv
module pwg_decide #(
  parameter int unsigned PW_W   = 64,
  localparam int unsigned CNT_W = $clog2(PW_W + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  pwg_pkg::cmd_e    cmd_i,
  input  logic [7:0]       arm_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [PW_W-1:0]  cand_i,
  input  logic [PW_W-1:0]  rd_pw_i,
  input  logic [PW_W-1:0]  full_pw_i,
  output logic             grant_o,
  output logic             deny_o
);
  logic len_ok, armed, hit_full, hit_rd, pass;

  always_comb begin
    len_ok   = (cnt_i == CNT_W'(PW_W));
    armed    = (arm_i == pwg_pkg::ARM_CODE);
    hit_full = (cand_i == full_pw_i);
    hit_rd   = (cand_i == rd_pw_i) && (cmd_i == pwg_pkg::CMD_READ);
    pass     = len_ok && (!armed || hit_full || hit_rd);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o <= 1'b0;
      deny_o  <= 1'b0;
    end else begin
      grant_o <= fire_i && pass;
      deny_o  <= fire_i && !pass;
    end
  end
endmodule

// File: rtl/pwd_access_gate.sv
module pwd_access_gate #(
  parameter int unsigned PW_BYTES = pwg_pkg::PW_BYTES_DEF,
  localparam int unsigned PW_W    = PW_BYTES * 8,
  localparam int unsigned ADDR_W  = $clog2(2 * PW_BYTES + 1),
  localparam int unsigned CNT_W   = $clog2(PW_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              cand_start_i,
  input  logic              cand_vld_i,
  input  logic              cand_bit_i,
  input  logic              cand_end_i,
  input  logic              cmd_copy_i,
  output logic              grant_o,
  output logic              deny_o
);
  logic [PW_W-1:0]  rd_pw, full_pw, cand;
  logic [7:0]       arm_byte;
  logic             rx_active;
  logic [CNT_W-1:0] rx_cnt;
  logic             fire;
  pwg_pkg::cmd_e    cmd;

  assign fire = cand_end_i && rx_active && !cand_start_i;
  assign cmd  = cmd_copy_i ? pwg_pkg::CMD_COPY : pwg_pkg::CMD_READ;

  pwg_cfg_regs #(.PW_BYTES(PW_BYTES)) i_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .rd_pw_o(rd_pw), .full_pw_o(full_pw), .arm_o(arm_byte)
  );

  pwg_rx #(.PW_W(PW_W)) i_rx (
    .clk_i, .rst_ni,
    .start_i(cand_start_i), .vld_i(cand_vld_i), .bit_i(cand_bit_i), .end_i(cand_end_i),
    .active_o(rx_active), .cnt_o(rx_cnt), .cand_o(cand)
  );

  pwg_decide #(.PW_W(PW_W)) i_dec (
    .clk_i, .rst_ni,
    .fire_i(fire), .cmd_i(cmd), .arm_i(arm_byte), .cnt_i(rx_cnt),
    .cand_i(cand), .rd_pw_i(rd_pw), .full_pw_i(full_pw),
    .grant_o, .deny_o
  );
endmodule

// File: rtl/pwg_checker.sv
module pwg_checker #(
  parameter int unsigned PW_BYTES = 8,
  localparam int unsigned PW_W    = PW_BYTES * 8,
  localparam int unsigned CNT_W   = $clog2(PW_W + 2)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cand_start_i,
  input logic             cand_end_i,
  input logic             grant_o,
  input logic             deny_o,
  input logic             rx_active,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [7:0]       arm_byte
);
  logic closing;
  assign closing = cand_end_i && rx_active && !cand_start_i;

  AST_ONE_DECISION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_o, deny_o})); // R8
  AST_PULSE_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    closing |=> (grant_o || deny_o)); // R8
  AST_NO_STRAY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !closing |=> !(grant_o || deny_o)); // R9
  AST_BAD_LEN_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (closing && rx_cnt != CNT_W'(PW_W)) |=> deny_o); // R5
  AST_DISARMED_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (closing && rx_cnt == CNT_W'(PW_W) && arm_byte != 8'hAA) |=> grant_o); // R2
endmodule

bind pwd_access_gate pwg_checker #(.PW_BYTES(PW_BYTES)) i_chk (
  .clk_i, .rst_ni, .cand_start_i, .cand_end_i, .grant_o, .deny_o,
  .rx_active(rx_active), .rx_cnt(rx_cnt), .arm_byte(arm_byte)
);

// File: tb/test_pwd_access_gate.sv
`timescale 1ns/1ps
module test_pwd_access_gate;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_we_i = 0; logic [4:0] cfg_addr_i = '0; logic [7:0] cfg_wdata_i = '0;
  logic cand_start_i = 0, cand_vld_i = 0, cand_bit_i = 0, cand_end_i = 0, cmd_copy_i = 0;
  logic grant_o, deny_o;

  int checks = 0, fails = 0, strays = 0;
  bit    exp_q[$];
  string tag_q[$];
  bit    prev_pulse = 0;

  always #10 clk_i = ~clk_i;   // 50 MHz

  pwd_access_gate i_pwd_access_gate (.*);

  localparam logic [63:0] RP  = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] FP  = 64'hF00D_1234_5678_9ABC;
  localparam logic [63:0] OTH = 64'h5555_AAAA_0F0F_F0F0;

  function automatic logic [63:0] rev64(input logic [63:0] v);
    for (int i = 0; i < 64; i++) rev64[i] = v[63-i];
  endfunction

  task automatic chk(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: %s", tag, what); end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk_i); cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i); cfg_we_i = 0;
  endtask

  task automatic load_pw(input logic [4:0] base, input logic [63:0] v);
    for (int b = 0; b < 8; b++) wr(base + 5'(b), v[8*b +: 8]);
  endtask

  // driver: sends nbits of v (bit 0 first), pushes expected decision
  task automatic send(input logic [63:0] v, input int nbits, input bit copy,
                      input bit exp_grant, input string tag);
    @(negedge clk_i); cand_start_i = 1;
    @(negedge clk_i); cand_start_i = 0;
    for (int i = 0; i < nbits; i++) begin
      cand_vld_i = 1; cand_bit_i = (i < 64) ? v[i] : 1'b0;
      @(negedge clk_i);
    end
    cand_vld_i = 0; cand_end_i = 1; cmd_copy_i = copy;
    exp_q.push_back(exp_grant); tag_q.push_back(tag);
    @(negedge clk_i); cand_end_i = 0; cmd_copy_i = 0;
    repeat (2) @(negedge clk_i);
  endtask

  // monitor
  initial forever begin
    @(negedge clk_i);
    if (rst_ni) begin
      if (grant_o || deny_o) begin
        if (exp_q.size() == 0) strays++;
        else begin
          bit e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          checks++;
          if (grant_o && deny_o) begin
            fails++; $display("FAIL R8: grant=1 deny=1 expected exactly one");
          end else if (grant_o != e) begin
            fails++; $display("FAIL %s: grant=%0b expected %0b", t, grant_o, e);
          end
        end
        if (prev_pulse) begin
          checks++; fails++; $display("FAIL R8: pulse held 2 cycles, expected 1");
        end
      end
      prev_pulse = grant_o || deny_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++; $display("FAIL watchdog: run hung, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!grant_o && !deny_o, "R1", $sformatf("in reset grant=%0b deny=%0b exp 0 0", grant_o, deny_o));
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    chk(!grant_o && !deny_o, "R1", $sformatf("after reset grant=%0b deny=%0b exp 0 0", grant_o, deny_o));

    send(OTH, 64, 0, 1, "R1");          // R1: starts disarmed, zero passwords
    send(64'h0,  64, 1, 1, "R2");       // R2
    send(OTH, 64, 1, 1, "R2");          // R2
    send(OTH, 63, 0, 0, "R5");          // R5
    send(OTH, 65, 1, 0, "R5");          // R5

    load_pw(5'd0, RP);                  // R7
    load_pw(5'd8, FP);                  // R7
    wr(5'd16, 8'hAB);                   // R10
    send(OTH, 64, 1, 1, "R10");         // R10
    wr(5'd16, 8'hAA);

    send(RP,  64, 0, 1, "R3");          // R3
    send(FP,  64, 0, 1, "R3");          // R3
    send(OTH, 64, 0, 0, "R3");          // R3
    send(FP,  64, 1, 1, "R4");          // R4
    send(RP,  64, 1, 0, "R4");          // R4
    send(OTH, 64, 1, 0, "R4");          // R4
    send(FP,  65, 1, 0, "R5");          // R5
    send(FP,  63, 0, 0, "R5");          // R5
    send(rev64(FP), 64, 1, 0, "R6");    // R6
    send(rev64(RP), 64, 0, 0, "R6");    // R6

    wr(5'd20, 8'h00); wr(5'd31, 8'hFF); // R7 unused addresses
    send(FP, 64, 1, 1, "R7");           // R7
    wr(5'd11, 8'h5A);                   // R7 byte 3 of full password
    send(FP, 64, 1, 0, "R7");           // R7
    send({FP[63:32], 8'h5A, FP[23:0]}, 64, 1, 1, "R7");

    // R9: end strobe and bits with no open candidate
    @(negedge clk_i); cand_vld_i = 1; cand_bit_i = 1;
    @(negedge clk_i); cand_vld_i = 0; cand_end_i = 1;
    @(negedge clk_i); cand_end_i = 0;
    repeat (3) @(negedge clk_i);
    chk(strays == 0, "R9", $sformatf("stray pulses=%0d expected 0", strays));

    // R9: start wins over an end strobe in the same cycle
    @(negedge clk_i); cand_start_i = 1; cand_end_i = 1;
    @(negedge clk_i); cand_start_i = 0; cand_end_i = 0;
    repeat (2) @(negedge clk_i);
    chk(strays == 0, "R9", $sformatf("pulse on start+end, strays=%0d expected 0", strays));
    send(RP, 64, 0, 1, "R9");           // R9: candidate still collects after that

    wr(5'd16, 8'h00);                   // R10 disarm again
    send(OTH, 64, 1, 1, "R10");         // R10

    repeat (4) @(negedge clk_i);
    chk(exp_q.size() == 0, "R8", $sformatf("missing decisions=%0d expected 0", exp_q.size()));
    chk(strays == 0, "R8", $sformatf("stray pulses=%0d expected 0", strays));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule